// File: doc/BRIEF.md
# Shader Branch and Writeout Unit

This block settles the control flow of a single shader thread, one branch word at a time. A branch word carries a 3-bit operation, either a 2-bit condition code (short format) or a 16-entry truth table (extended format), and a signed offset. Alongside it the block receives four condition bits, the thread's current PC, and status from the tile buffer: a ready level and a response strobe that either accepts or rejects a pending write. One cycle after a branch word is accepted, the block reports the next PC. Only a discard that fires or a pending writeout holds this report back.

Some fixed-function operations are expressed as branches. A discard ends the thread when its condition holds. A tile-wait branch stays on its target while the tile buffer is busy, so an offset of -1 gives a spin loop. A writeout raises a write request and keeps it up until the tile buffer responds. If the buffer accepts the write, the thread ends. If it rejects the write, control passes to the branch target so that the thread can retry. Once the thread has ended or been discarded, the block ignores branch words until reset.

Top module: `shader_flow_unit`

## Requirements
- R1: After reset, pc_valid, wr_req, terminated and discarded are 0 and pc_next is 0.
- R2: Opcode 1 (jump) is always taken. One cycle after the word is accepted, pc_valid pulses for one cycle with pc_next = pc_in + offset, computed modulo 2^PC_W.
- R3: Opcode 2 (conditional) in short format (br_ext = 0) uses the 2-bit code as a table indexed by cond_bits[0]. Code 0 never branches, code 1 branches when bit 0 is 0, code 2 branches when bit 0 is 1, and code 3 always branches. A branch that is not taken gives pc_next = pc_in + 1.
- R4: A short-format offset is br_offset[6:0], sign-extended, and the upper bits of br_offset are ignored. An extended-format offset is all 23 bits of br_offset, signed. When PC_W is narrower than 23 bits, the offset is reduced modulo 2^PC_W.
- R5: In extended format (br_ext = 1), the condition result is br_table[cond_bits], where cond_bits = {D,C,B,A} and A is the least significant bit.
- R6: Opcode 4 (discard) sets discarded one cycle after acceptance when its condition holds, and gives no pc_valid pulse. When the condition does not hold, it reports pc_in + 1.
- R7: Opcode 6 (tile wait) is taken when its condition holds and tb_ready is 0. When tb_ready is 1, it reports pc_in + 1.
- R8: Opcode 7 (writeout) raises wr_req one cycle after acceptance. wr_req stays high until a cycle with tb_ack = 1. While wr_req is high, pc_valid stays 0 and branch words are ignored.
- R9: On a tb_ack cycle with tb_accept = 1, terminated rises and wr_req falls on the next cycle. With tb_accept = 0, wr_req falls and pc_valid pulses with pc_next set to the writeout's target.
- R10: While terminated or discarded is 1, branch words are ignored: pc_valid and wr_req stay 0 and pc_next holds until reset. terminated and discarded are never both 1.
- R11: Opcodes 0, 3 and 5 are never taken and report pc_in + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_valid | input | 1 | A branch word is present this cycle |
| br_op | input | 3 | Branch operation |
| br_ext | input | 1 | 1 selects the extended format (table condition, wide offset) |
| br_code | input | 2 | Short-format condition code |
| br_table | input | TABLE_W | Extended-format truth table |
| br_offset | input | LONG_OFF_W | Signed offset; short format uses the low SHORT_OFF_W bits |
| cond_bits | input | log2(TABLE_W) | Condition bits {D,C,B,A} |
| pc_in | input | PC_W | PC of the branch word |
| tb_ready | input | 1 | Tile buffer ready |
| tb_ack | input | 1 | Single-cycle response strobe for a pending write |
| tb_accept | input | 1 | With tb_ack: 1 means the write was accepted, 0 means rejected |
| pc_next | output | PC_W | Next PC |
| pc_valid | output | 1 | One-cycle pulse when pc_next is updated |
| wr_req | output | 1 | Writeout request to the tile buffer |
| terminated | output | 1 | Thread ended after a successful writeout |
| discarded | output | 1 | Thread ended by a discard |

## Verification
The bench builds the block with PC_W = 16 and keeps the default 7-bit and 23-bit offsets and the 16-entry table. With these values a PC increment can wrap from 0xFFFF to 0. The extended offset is also wider than the PC, so the truncating variant of the target adder is elaborated, and wide negative offsets can be checked modulo 2^16. Any truth-table index and short-offset pattern can still be reached from the vector table.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam logic [2:0] OP_JUMP      = 3'd1;
  localparam logic [2:0] OP_CJUMP     = 3'd2;
  localparam logic [2:0] OP_KILL      = 3'd4;
  localparam logic [2:0] OP_TILE_WAIT = 3'd6;
  localparam logic [2:0] OP_WRITE     = 3'd7;

  // Taken decision of an operation, given the evaluated condition.
  function automatic logic op_taken(logic [2:0] op, logic hit, logic ready);
    case (op)
      OP_JUMP:      return 1'b1;
      OP_CJUMP:     return hit;
      OP_TILE_WAIT: return hit & ~ready;
      default:      return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sfu_cond_eval.sv
module sfu_cond_eval #(
  parameter int TABLE_W = 16,
  localparam int IDX_W = $clog2(TABLE_W)
) (
  input  logic               ext,
  input  logic [1:0]         code,
  input  logic [TABLE_W-1:0] table_bits,
  input  logic [IDX_W-1:0]   cond_bits,
  output logic               hit
);
  // Short codes form a two-entry table over condition A.
  function automatic logic short_hit(logic [1:0] c, logic a);
    return c[a];
  endfunction

  function automatic logic table_hit(logic [TABLE_W-1:0] t, logic [IDX_W-1:0] idx);
    return t[idx];
  endfunction

  assign hit = ext ? table_hit(table_bits, cond_bits) : short_hit(code, cond_bits[0]);
endmodule

// File: rtl/sfu_target_calc.sv
module sfu_target_calc #(
  parameter int PC_W    = 32,
  parameter int SHORT_W = 7,
  parameter int LONG_W  = 23
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [LONG_W-1:0] offset,
  input  logic              ext,
  output logic [PC_W-1:0]   target,
  output logic [PC_W-1:0]   seq
);
  logic [PC_W-1:0] short_ext;
  logic [PC_W-1:0] long_ext;

  assign short_ext = {{(PC_W-SHORT_W){offset[SHORT_W-1]}}, offset[SHORT_W-1:0]};

  generate
    if (LONG_W >= PC_W) begin : g_long_trunc
      assign long_ext = offset[PC_W-1:0];
    end else begin : g_long_sext
      assign long_ext = {{(PC_W-LONG_W){offset[LONG_W-1]}}, offset};
    end
  endgenerate

  function automatic logic [PC_W-1:0] add_pc(logic [PC_W-1:0] a, logic [PC_W-1:0] b);
    return a + b;
  endfunction

  assign target = add_pc(pc, ext ? long_ext : short_ext);
  assign seq    = add_pc(pc, {{(PC_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/sfu_write_wait.sv
module sfu_write_wait (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  input  logic accept,
  output logic pending,
  output logic done_ok,
  output logic done_fail
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pend_q <= 1'b0;
    else if (pend_q & ack) pend_q <= 1'b0;
    else if (start)        pend_q <= 1'b1;
  end

  assign pending   = pend_q;
  assign done_ok   = pend_q & ack & accept;
  assign done_fail = pend_q & ack & ~accept;
endmodule

// File: rtl/shader_flow_unit.sv
module shader_flow_unit
  import sfu_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int SHORT_OFF_W = 7,
  parameter int LONG_OFF_W = 23,
  parameter int TABLE_W    = 16,
  localparam int COND_W    = $clog2(TABLE_W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  br_valid,
  input  logic [2:0]            br_op,
  input  logic                  br_ext,
  input  logic [1:0]            br_code,
  input  logic [TABLE_W-1:0]    br_table,
  input  logic [LONG_OFF_W-1:0] br_offset,
  input  logic [COND_W-1:0]     cond_bits,
  input  logic [PC_W-1:0]       pc_in,
  input  logic                  tb_ready,
  input  logic                  tb_ack,
  input  logic                  tb_accept,
  output logic [PC_W-1:0]       pc_next,
  output logic                  pc_valid,
  output logic                  wr_req,
  output logic                  terminated,
  output logic                  discarded
);
  logic            cond_hit;
  logic            take_w;
  logic            accept_w;
  logic            wr_start;
  logic            wr_ok;
  logic            wr_fail;
  logic [PC_W-1:0] target_w;
  logic [PC_W-1:0] seq_w;

  logic [PC_W-1:0] pc_next_q;
  logic [PC_W-1:0] wr_target_q;
  logic            pc_valid_q;
  logic            term_q;
  logic            disc_q;

  sfu_cond_eval #(.TABLE_W(TABLE_W)) u_cond (
    .ext        (br_ext),
    .code       (br_code),
    .table_bits (br_table),
    .cond_bits  (cond_bits),
    .hit        (cond_hit)
  );

  sfu_target_calc #(.PC_W(PC_W), .SHORT_W(SHORT_OFF_W), .LONG_W(LONG_OFF_W)) u_tgt (
    .pc     (pc_in),
    .offset (br_offset),
    .ext    (br_ext),
    .target (target_w),
    .seq    (seq_w)
  );

  // A branch word is taken up only while the thread is live and no write waits.
  assign accept_w = br_valid & ~term_q & ~disc_q & ~wr_req;
  assign wr_start = accept_w & (br_op == OP_WRITE);
  assign take_w   = op_taken(br_op, cond_hit, tb_ready);

  sfu_write_wait u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (wr_start),
    .ack       (tb_ack),
    .accept    (tb_accept),
    .pending   (wr_req),
    .done_ok   (wr_ok),
    .done_fail (wr_fail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_next_q   <= '0;
      wr_target_q <= '0;
      pc_valid_q  <= 1'b0;
      term_q      <= 1'b0;
      disc_q      <= 1'b0;
    end else begin
      pc_valid_q <= 1'b0;
      if (wr_ok) begin
        term_q <= 1'b1;
      end else if (wr_fail) begin
        pc_valid_q <= 1'b1;
        pc_next_q  <= wr_target_q;
      end else if (accept_w) begin
        case (br_op)
          OP_WRITE: wr_target_q <= target_w;
          OP_KILL: begin
            if (cond_hit) begin
              disc_q <= 1'b1;
            end else begin
              pc_valid_q <= 1'b1;
              pc_next_q  <= seq_w;
            end
          end
          default: begin
            pc_valid_q <= 1'b1;
            pc_next_q  <= take_w ? target_w : seq_w;
          end
        endcase
      end
    end
  end

  assign pc_next    = pc_next_q;
  assign pc_valid   = pc_valid_q;
  assign terminated = term_q;
  assign discarded  = disc_q;
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept_w,
  input logic [2:0]      br_op,
  input logic            br_ext,
  input logic [6:0]      br_off_lo,
  input logic [PC_W-1:0] pc_in,
  input logic            tb_ready,
  input logic            tb_ack,
  input logic            tb_accept,
  input logic [PC_W-1:0] pc_next,
  input logic            pc_valid,
  input logic            wr_req,
  input logic            terminated,
  input logic            discarded
);
  AST_JUMP_BACK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && br_op == 3'd1 && !br_ext && br_off_lo == 7'h7f
    |=> pc_valid && pc_next == $past(pc_in) - 1'b1); // R2

  AST_TILE_READY_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && br_op == 3'd6 && tb_ready
    |=> pc_valid && pc_next == $past(pc_in) + 1'b1); // R7

  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !tb_ack |=> wr_req); // R8

  AST_WR_NO_PC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !pc_valid); // R8

  AST_WR_ACCEPT_END: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && tb_ack && tb_accept |=> terminated && !wr_req && !pc_valid); // R9

  AST_WR_REJECT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && tb_ack && !tb_accept |=> pc_valid && !wr_req && !terminated); // R9

  AST_END_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (terminated || discarded)
    |=> $stable(terminated) && $stable(discarded) && !pc_valid && !wr_req
        && $stable(pc_next)); // R10

  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(terminated && discarded)); // R10
endmodule

bind shader_flow_unit sfu_checker #(.PC_W(PC_W)) i_sfu_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept_w   (accept_w),
  .br_op      (br_op),
  .br_ext     (br_ext),
  .br_off_lo  (br_offset[6:0]),
  .pc_in      (pc_in),
  .tb_ready   (tb_ready),
  .tb_ack     (tb_ack),
  .tb_accept  (tb_accept),
  .pc_next    (pc_next),
  .pc_valid   (pc_valid),
  .wr_req     (wr_req),
  .terminated (terminated),
  .discarded  (discarded)
);

// File: tb/test_shader_flow_unit.sv
module test_shader_flow_unit;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          br_valid = 1'b0;
  logic [2:0]    br_op = '0;
  logic          br_ext = 1'b0;
  logic [1:0]    br_code = '0;
  logic [15:0]   br_table = '0;
  logic [22:0]   br_offset = '0;
  logic [3:0]    cond_bits = '0;
  logic [PW-1:0] pc_in = '0;
  logic          tb_ready = 1'b0;
  logic          tb_ack = 1'b0;
  logic          tb_accept = 1'b0;
  logic [PW-1:0] pc_next;
  logic          pc_valid, wr_req, terminated, discarded;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  shader_flow_unit #(.PC_W(PW)) i_shader_flow_unit (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_op(br_op), .br_ext(br_ext),
    .br_code(br_code), .br_table(br_table), .br_offset(br_offset), .cond_bits(cond_bits),
    .pc_in(pc_in), .tb_ready(tb_ready), .tb_ack(tb_ack), .tb_accept(tb_accept),
    .pc_next(pc_next), .pc_valid(pc_valid), .wr_req(wr_req),
    .terminated(terminated), .discarded(discarded));

  typedef struct packed {
    logic [2:0]    op;
    logic          ext;
    logic [1:0]    code;
    logic [15:0]   tbl;
    logic [22:0]   off;
    logic [3:0]    cnd;
    logic          rdy;
    logic [15:0]   pc;
    logic          taken;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 1'b0, 2'd0, 16'h0000, 23'h000005, 4'h0, 1'b0, 16'h0100, 1'b1}, // R2 forward
    '{3'd1, 1'b0, 2'd0, 16'h0000, 23'h00007F, 4'h0, 1'b0, 16'h0100, 1'b1}, // R2 back by one
    '{3'd2, 1'b0, 2'd0, 16'h0000, 23'h000010, 4'h1, 1'b0, 16'h0200, 1'b0}, // R3 code 0
    '{3'd2, 1'b0, 2'd1, 16'h0000, 23'h000040, 4'hE, 1'b0, 16'h0200, 1'b1}, // R3 code 1, A=0
    '{3'd2, 1'b0, 2'd1, 16'h0000, 23'h000040, 4'h1, 1'b0, 16'h0200, 1'b0}, // R3 code 1, A=1
    '{3'd2, 1'b0, 2'd2, 16'h0000, 23'h000020, 4'h1, 1'b0, 16'h0300, 1'b1}, // R3 code 2, A=1
    '{3'd2, 1'b0, 2'd2, 16'h0000, 23'h000020, 4'hE, 1'b0, 16'h0300, 1'b0}, // R3 code 2, A=0
    '{3'd2, 1'b0, 2'd3, 16'h0000, 23'h000070, 4'h0, 1'b0, 16'h0008, 1'b1}, // R3 code 3, wraps
    '{3'd2, 1'b1, 2'd0, 16'h8000, 23'h7FFFF0, 4'hF, 1'b0, 16'h1000, 1'b1}, // R5 index 15
    '{3'd2, 1'b1, 2'd3, 16'h8000, 23'h7FFFF0, 4'hE, 1'b0, 16'h1000, 1'b0}, // R5 index 14
    '{3'd2, 1'b1, 2'd0, 16'h0004, 23'h000200, 4'h2, 1'b0, 16'h1000, 1'b1}, // R5 index 2
    '{3'd2, 1'b1, 2'd3, 16'hFFFB, 23'h000200, 4'h2, 1'b0, 16'h1000, 1'b0}, // R5 only bit 2 low
    '{3'd1, 1'b1, 2'd0, 16'h0000, 23'h412345, 4'h0, 1'b0, 16'h0010, 1'b1}, // R4 wide offset
    '{3'd2, 1'b0, 2'd3, 16'h0000, 23'h7FFF03, 4'h0, 1'b0, 16'h0400, 1'b1}, // R4 upper bits ignored
    '{3'd6, 1'b0, 2'd3, 16'h0000, 23'h00007F, 4'h0, 1'b0, 16'h0500, 1'b1}, // R7 spin
    '{3'd6, 1'b0, 2'd3, 16'h0000, 23'h00007F, 4'h0, 1'b1, 16'h0500, 1'b0}, // R7 ready
    '{3'd6, 1'b0, 2'd0, 16'h0000, 23'h00007F, 4'h0, 1'b0, 16'h0500, 1'b0}, // R7 code never
    '{3'd4, 1'b0, 2'd1, 16'h0000, 23'h000010, 4'h1, 1'b0, 16'h0600, 1'b0}, // R6 no discard
    '{3'd0, 1'b0, 2'd3, 16'h0000, 23'h000010, 4'h0, 1'b0, 16'hFFFF, 1'b0}, // R11 op 0, wraps
    '{3'd3, 1'b0, 2'd3, 16'h0000, 23'h000010, 4'h0, 1'b0, 16'h0700, 1'b0}, // R11 op 3
    '{3'd5, 1'b1, 2'd3, 16'hFFFF, 23'h000010, 4'h0, 1'b0, 16'h0800, 1'b0}  // R11 op 5
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Model of the target: pc plus the signed offset, modulo 2^16.
  function automatic logic [15:0] exp_target(logic [15:0] pc, logic ext, logic [22:0] off);
    int o;
    o = ext ? int'($signed(off)) : int'($signed(off[6:0]));
    return 16'(int'(pc) + o);
  endfunction

  function automatic string req_of(logic [2:0] op, logic ext);
    if (op == 3'd1) return "R2/R4";
    if (op == 3'd2) return ext ? "R5" : "R3";
    if (op == 3'd6) return "R7";
    if (op == 3'd4) return "R6";
    return "R11";
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    br_valid = 1'b0; tb_ack = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(logic [2:0] op, logic ext, logic [1:0] code, logic [15:0] tbl,
                       logic [22:0] off, logic [3:0] cnd, logic rdy, logic [15:0] pc);
    br_op = op; br_ext = ext; br_code = code; br_table = tbl;
    br_offset = off; cond_bits = cnd; tb_ready = rdy; pc_in = pc;
    br_valid = 1'b1;
    @(negedge clk);
    br_valid = 1'b0;
  endtask

  task automatic respond(logic acc);
    tb_ack = 1'b1; tb_accept = acc;
    @(negedge clk);
    tb_ack = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 pc_valid", 32'(pc_valid), 0);
    chk("R1 wr_req", 32'(wr_req), 0);
    chk("R1 terminated", 32'(terminated), 0);
    chk("R1 discarded", 32'(discarded), 0);
    chk("R1 pc_next", 32'(pc_next), 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [15:0] e;
      v = VEC[i];
      issue(v.op, v.ext, v.code, v.tbl, v.off, v.cnd, v.rdy, v.pc);
      e = v.taken ? exp_target(v.pc, v.ext, v.off) : 16'(v.pc + 16'd1);
      chk(req_of(v.op, v.ext), 32'(pc_valid), 1);
      chk(req_of(v.op, v.ext), 32'(pc_next), 32'(e));
      @(negedge clk);
      chk("R2 pulse length", 32'(pc_valid), 0);
    end

    // Writeout rejected, then retried target reported (R8, R9)
    issue(3'd7, 1'b0, 2'd3, 16'h0, 23'h00007E, 4'h0, 1'b1, 16'h0200);
    chk("R8 wr_req raised", 32'(wr_req), 1);
    chk("R8 no pc while waiting", 32'(pc_valid), 0);
    issue(3'd1, 1'b0, 2'd0, 16'h0, 23'h000005, 4'h0, 1'b1, 16'h0900);
    chk("R8 word ignored while waiting", 32'(pc_valid), 0);
    @(negedge clk);
    chk("R8 wr_req held", 32'(wr_req), 1);
    respond(1'b0);
    chk("R9 reject drops wr_req", 32'(wr_req), 0);
    chk("R9 reject pc_valid", 32'(pc_valid), 1);
    chk("R9 reject target", 32'(pc_next), 32'h01FE);
    chk("R9 reject no terminate", 32'(terminated), 0);

    // Discard taken, then words ignored (R6, R10)
    issue(3'd4, 1'b0, 2'd2, 16'h0, 23'h000010, 4'h1, 1'b1, 16'h0A00);
    chk("R6 discarded", 32'(discarded), 1);
    chk("R6 no pc_valid", 32'(pc_valid), 0);
    issue(3'd1, 1'b0, 2'd0, 16'h0, 23'h000005, 4'h0, 1'b1, 16'h0B00);
    chk("R10 jump ignored", 32'(pc_valid), 0);
    chk("R10 pc_next held", 32'(pc_next), 32'h01FE);
    issue(3'd7, 1'b0, 2'd3, 16'h0, 23'h000005, 4'h0, 1'b1, 16'h0B00);
    chk("R10 writeout ignored", 32'(wr_req), 0);
    chk("R10 discarded sticky", 32'(discarded), 1);

    // Reset clears, writeout accepted ends thread (R1, R9, R10)
    do_reset();
    chk("R1 discarded cleared", 32'(discarded), 0);
    issue(3'd7, 1'b1, 2'd0, 16'h0, 23'h000100, 4'h0, 1'b1, 16'h0C00);
    chk("R8 wr_req extended", 32'(wr_req), 1);
    respond(1'b1);
    chk("R9 terminated", 32'(terminated), 1);
    chk("R9 accept drops wr_req", 32'(wr_req), 0);
    chk("R9 accept no pc_valid", 32'(pc_valid), 0);
    issue(3'd2, 1'b0, 2'd3, 16'h0, 23'h000005, 4'h0, 1'b1, 16'h0D00);
    chk("R10 ignored after end", 32'(pc_valid), 0);
    chk("R10 not discarded", 32'(discarded), 0);
    chk("R10 terminated sticky", 32'(terminated), 1);

    summary();
    $finish;
  end
endmodule